// File: doc/BRIEF.md
# Flash key-sequence unlock controller

This block guards program and erase access to on-chip non-volatile memory. Software must write two fixed key bytes, first 0xA5 and then 0xF1, to one 8-bit control register before a single flash operation is allowed. Any number of idle cycles may separate the two key writes. Each granted operation relocks the block, so every further operation needs a fresh key pair.

The unlock is deliberately fragile. A key byte out of order, any write while the block is already unlocked, or an operation request made before the unlock completes all put the block into a disabled state. That state ignores everything until a synchronous system reset. A register read returns the current state in the two low bits of the byte. The permit output is the only grant path to the flash sequencer.

Top module: `flash_key_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the locked state (code 00). After that reset, `op_permit` and `lockout` are low and a read returns 0x00.
- R2: In the locked state a write of 0xA5 moves the state to 01. In state 01 a write of 0xF1 moves it to unlocked (code 10). Idle cycles between the two writes have no effect.
- R3: In state 00, a write of any byte other than 0xA5 moves the state to disabled (code 11). In state 01, a write of any byte other than 0xF1 also moves it to 11. This includes a second 0xA5.
- R4: An `op_req` in state 00 or 01 keeps `op_permit` low in that cycle and moves the state to 11. This holds whether or not a write arrives in the same cycle.
- R5: An `op_req` in state 10 raises `op_permit` combinationally in that same cycle only. If no write arrives in that cycle, the state becomes 00 at the next edge.
- R6: Any register write in state 10 without `op_req` moves the state to 11.
- R7: In state 11, `lockout` is high, `op_permit` stays low, and writes and requests leave the state at 11 until reset.
- R8: When `rd_en` is high, `rd_data` is {6'b0, state code}, showing the state before the current edge. When `rd_en` is low, `rd_data` is 0x00.
- R9: When `op_req` and a write coincide in state 10, `op_permit` is high in that cycle and the state becomes 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Control register read strobe |
| op_req | input | 1 | Flash operation request pulse |
| rd_data | output | 8 | Read data, state code in bits 1:0 |
| op_permit | output | 1 | Operation granted in this cycle |
| lockout | output | 1 | Disabled until reset |

## Verification
An operation request and a register write can land in the same cycle. In that cycle the block must both decide the grant and classify the write. The bench drives both strobes together in each of the locked, first-key and unlocked states. In the locked and first-key states it expects no grant and a move to 11. In the unlocked state it expects a one-cycle grant followed by state 11. A read in the same cycle is checked against the pre-edge state, and the reference model is compared against all three outputs on every clock.

// File: rtl/flk_pkg.sv
package flk_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'b00,
        ST_KEY1   = 2'b01,
        ST_OPEN   = 2'b10,
        ST_DEAD   = 2'b11
    } lk_state_e;

    typedef struct packed {
        lk_state_e state;
    } lk_regs_t;
endpackage

// File: rtl/flk_key_match.sv
module flk_key_match
    import flk_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  KEY_FIRST  = 8'hA5,
    parameter logic [7:0]  KEY_SECOND = 8'hF1
) (
    input  lk_state_e          state,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               key_ok
);
    always_comb begin
        unique case (state)
            ST_LOCKED: key_ok = (wr_data == DATA_W'(KEY_FIRST));
            ST_KEY1:   key_ok = (wr_data == DATA_W'(KEY_SECOND));
            default:   key_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/flk_fsm.sv
module flk_fsm
    import flk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      op_req,
    input  logic      key_ok,
    output lk_state_e state_q,
    output logic      permit
);
    lk_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        permit = 1'b0;
        unique case (r_q.state)
            ST_LOCKED, ST_KEY1: begin
                if (op_req)
                    r_d.state = ST_DEAD;
                else if (wr_en)
                    r_d.state = key_ok ? ((r_q.state == ST_LOCKED) ? ST_KEY1 : ST_OPEN)
                                       : ST_DEAD;
            end
            ST_OPEN: begin
                if (op_req) begin
                    permit    = 1'b1;
                    r_d.state = wr_en ? ST_DEAD : ST_LOCKED;
                end else if (wr_en) begin
                    r_d.state = ST_DEAD;
                end
            end
            default: r_d.state = ST_DEAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_LOCKED};
        else     r_q <= r_d;
    end

    assign state_q = r_q.state;
endmodule

// File: rtl/flk_status.sv
module flk_status
    import flk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rd_en,
    input  lk_state_e         state,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - 2;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = rd_en ? {{PAD_W{1'b0}}, state} : '0;
        end else begin : g_nopad
            assign rd_data = rd_en ? state[DATA_W-1:0] : '0;
        end
    endgenerate
endmodule

// File: rtl/flash_key_gate.sv
module flash_key_gate
    import flk_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter logic [7:0] KEY_FIRST  = 8'hA5,
    parameter logic [7:0] KEY_SECOND = 8'hF1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              op_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              op_permit,
    output logic              lockout
);
    lk_state_e state_q;
    logic      key_ok;

    flk_key_match #(.DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_match (
        .state   (state_q),
        .wr_data (wr_data),
        .key_ok  (key_ok)
    );

    flk_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .op_req  (op_req),
        .key_ok  (key_ok),
        .state_q (state_q),
        .permit  (op_permit)
    );

    flk_status #(.DATA_W(DATA_W)) u_status (
        .rd_en   (rd_en),
        .state   (state_q),
        .rd_data (rd_data)
    );

    assign lockout = (state_q == ST_DEAD);
endmodule

// File: rtl/flk_gate_chk.sv
module flk_gate_chk
    import flk_pkg::*;
#(
    parameter int         DATA_W    = 8,
    parameter logic [7:0] KEY_FIRST = 8'hA5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              op_req,
    input logic              op_permit,
    input logic              lockout,
    input lk_state_e         state_q
);
    // R5
    permit_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        op_permit |-> (op_req && state_q == ST_OPEN));
    // R5
    permit_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        op_permit |=> !op_permit);
    // R7
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lockout |=> lockout);
    // R4
    early_op_kills_chk: assert property (@(posedge clk) disable iff (rst)
        (op_req && (state_q == ST_LOCKED || state_q == ST_KEY1)) |=> lockout);
    // R3
    bad_first_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !op_req && state_q == ST_LOCKED && wr_data != DATA_W'(KEY_FIRST)) |=> lockout);
    // R9
    op_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_permit && wr_en) |=> lockout);
endmodule

bind flash_key_gate flk_gate_chk #(.DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_req    (op_req),
    .op_permit (op_permit),
    .lockout   (lockout),
    .state_q   (state_q)
);

// File: tb/sim_flash_key_gate.sv
`timescale 1ns/1ps
module sim_flash_key_gate;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       op_req = 1'b0;
    logic [7:0] rd_data;
    logic       op_permit;
    logic       lockout;

    int checks = 0;
    int fails  = 0;
    int model  = 0;   // 0 locked, 1 first key, 2 open, 3 disabled

    always #2.5 clk = ~clk;

    flash_key_gate u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .op_req(op_req), .rd_data(rd_data),
        .op_permit(op_permit), .lockout(lockout)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit w, input logic [7:0] d,
                        input bit r, input bit op);
        int nxt;
        bit exp_permit;
        @(negedge clk);
        wr_en = w; wr_data = d; rd_en = r; op_req = op;
        #1;
        exp_permit = op && (model == 2);
        check(tag, "op_permit", int'(op_permit), int'(exp_permit));
        check(tag, "lockout", int'(lockout), int'(model == 3));
        check(tag, "rd_data", int'(rd_data), r ? model : 0);
        nxt = model;
        if (model == 3)          nxt = 3;
        else if (op)             nxt = (model == 2 && !w) ? 0 : 3;
        else if (w) begin
            if (model == 0)      nxt = (d == 8'hA5) ? 1 : 3;
            else if (model == 1) nxt = (d == 8'hF1) ? 2 : 3;
            else                 nxt = 3;
        end
        @(posedge clk);
        model = nxt;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 8'h00, 1, 0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; wr_en = 0; rd_en = 0; op_req = 0;
        @(posedge clk);
        model = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        step("R1", 0, 8'h00, 1, 0);
        step("R8", 0, 8'h00, 0, 0);
        // unlock with gaps, then operate
        step("R2", 1, 8'hA5, 1, 0);
        idle("R2", 5);
        step("R2", 1, 8'hF1, 1, 0);
        idle("R2", 3);
        step("R5", 0, 8'h00, 1, 1);
        step("R5", 0, 8'h00, 1, 0);
        // fresh pair for second op
        step("R2", 1, 8'hA5, 0, 0);
        step("R2", 1, 8'hF1, 0, 0);
        step("R5", 0, 8'h00, 1, 1);
        // op while locked -> disabled
        step("R4", 0, 8'h00, 1, 1);
        step("R7", 1, 8'hA5, 1, 0);
        step("R7", 1, 8'hF1, 1, 1);
        step("R7", 0, 8'h00, 1, 1);
        idle("R7", 2);
        do_reset();
        step("R1", 0, 8'h00, 1, 0);
        // wrong first key
        step("R3", 1, 8'h5A, 1, 0);
        idle("R3", 1);
        do_reset();
        // wrong second key, incl. repeated first key
        step("R3", 1, 8'hA5, 1, 0);
        step("R3", 1, 8'hA5, 1, 0);
        idle("R3", 1);
        do_reset();
        step("R3", 1, 8'hA5, 1, 0);
        step("R3", 1, 8'hF0, 1, 0);
        idle("R3", 1);
        do_reset();
        // write while open
        step("R6", 1, 8'hA5, 1, 0);
        step("R6", 1, 8'hF1, 1, 0);
        step("R6", 1, 8'hA5, 1, 0);
        idle("R6", 1);
        do_reset();
        // op in first-key state with write
        step("R4", 1, 8'hA5, 1, 0);
        step("R4", 1, 8'hF1, 1, 1);
        idle("R4", 1);
        do_reset();
        // op in locked with write of first key
        step("R4", 1, 8'hA5, 1, 1);
        idle("R4", 1);
        do_reset();
        // op and write together while open
        step("R9", 1, 8'hA5, 1, 0);
        step("R9", 1, 8'hF1, 1, 0);
        step("R9", 1, 8'h00, 1, 1);
        step("R9", 0, 8'h00, 1, 1);
        idle("R9", 1);
        // reset in first-key state restarts sequence
        do_reset();
        step("R1", 1, 8'hA5, 1, 0);
        do_reset();
        step("R1", 1, 8'hF1, 1, 0);
        idle("R1", 1);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule